// File: doc/BRIEF.md
# Parallel Flash Programming Command Interface

This block is the device end of a byte-wide programming port. An external programmer frames each command by pulling an active-low chip select low. It clocks bytes in with pulses on a strobe pin and exchanges data over an 8-bit bus, which is modelled here as separate input, output and output-enable ports. Both control pins are brought into the system clock domain through two-flop synchronisers. Bytes are taken on the rising edges of the synchronised strobe.

A command is a fixed 0xAA preamble, then an opcode, then the high and low address bytes, then one data byte if the command is a write. A write stores its byte in an internal array and holds the ready output low for a fixed number of system clocks. A read turns the bus around after the fourth strobe pulse ends and keeps presenting the stored byte until chip select is released. Whenever chip select is high, the command logic returns to idle and the bus is released.

Top module: `pflash_cmd_port`

## Requirements
- R1: While chip select (csn_i) is high, bus_oe is 0 and the command logic waits for a new preamble.
- R2: Bytes are taken from bus_i on rising strobe edges, in the order 0xAA, opcode, address high, address low, then one data byte for a write.
- R3: If the first byte after chip select falls is not 0xAA, every following strobe is ignored until chip select rises.
- R4: Opcode 0x01 stores the data byte at the addressed location.
- R5: Opcode 0x02 sets bus_oe to 1 only after the falling edge of the fourth strobe pulse (the address-low byte), and bus_o then carries the stored byte.
- R6: Once driven, read data and bus_oe stay unchanged until chip select rises, and bus_oe then returns to 0.
- R7: Any opcode other than 0x01 or 0x02 leaves the memory unchanged.
- R8: After a write data byte is captured, rdy_o is 0 for exactly WR_CYCLES system clocks. At all other times it is 1.
- R9: Strobe pulses that arrive while rdy_o is 0 are ignored.
- R10: The location used is the low $clog2(MEM_BYTES) bits of {address high, address low}. Higher address bits are ignored.
- R11: Raising chip select in the middle of a command abandons that command, and the next framed command is decoded from its preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Active-low command frame select, asynchronous |
| strb_i | input | 1 | Byte strobe, asynchronous |
| bus_i | input | 8 | Bus value seen at the pins |
| bus_o | output | 8 | Read data driven onto the bus |
| bus_oe | output | 1 | Bus output enable, 1 drives bus_o |
| rdy_o | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions assume three things about the inputs: each strobe level and each chip-select level lasts several system clocks, bus_i is stable around every rising strobe edge, and the programmer leaves chip select low until the last byte has been strobed. The stimulus keeps every strobe phase at least three clocks long. It changes bus_i only while the strobe is low. It issues random addresses, data and illegal opcodes through the same timed byte tasks that the directed cases use.

// File: rtl/pflash_cmd_port.sv
module pflash_cmd_port #(
  parameter int MEM_BYTES = 4096,
  parameter int WR_CYCLES = 32,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csn_i,
  input  logic       strb_i,
  input  logic [7:0] bus_i,
  output logic [7:0] bus_o,
  output logic       bus_oe,
  output logic       rdy_o
);

  typedef enum logic [2:0] {
    S_PRE, S_OP, S_AH, S_AL, S_DAT, S_RWAIT, S_RD, S_DEAD
  } st_t;

  localparam logic [7:0] PREAMBLE = 8'hAA;
  localparam logic [7:0] OP_WR    = 8'h01;
  localparam logic [7:0] OP_RD    = 8'h02;

  logic [1:0]    cs_sync, strb_sync;
  logic          strb_d;
  st_t           st;
  logic [7:0]    op_q, ah_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;
  logic [7:0]    rd_q;
  logic          oe_q;
  logic [7:0]    mem [MEM_BYTES];

  wire cs_idle = cs_sync[1];
  wire rise    = strb_sync[1] & ~strb_d;
  wire fall    = ~strb_sync[1] & strb_d;
  wire busy    = (cnt != '0);
  wire take    = rise & ~busy & ~cs_idle;
  wire we      = take & (st == S_DAT);

  assign rdy_o  = ~busy;
  assign bus_oe = oe_q;
  assign bus_o  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= 2'b11;
      strb_sync <= 2'b00;
      strb_d    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[0], csn_i};
      strb_sync <= {strb_sync[0], strb_i};
      strb_d    <= strb_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PRE;
      op_q   <= '0;
      ah_q   <= '0;
      addr_q <= '0;
    end else if (cs_idle) begin
      st <= S_PRE;
    end else if (take) begin
      case (st)
        S_PRE: st <= (bus_i == PREAMBLE) ? S_OP : S_DEAD;
        S_OP: begin
          op_q <= bus_i;
          st   <= S_AH;
        end
        S_AH: begin
          ah_q <= bus_i;
          st   <= S_AL;
        end
        S_AL: begin
          addr_q <= AW'({ah_q, bus_i});
          st     <= (op_q == OP_WR) ? S_DAT : (op_q == OP_RD) ? S_RWAIT : S_DEAD;
        end
        S_DAT:   st <= S_DEAD;
        default: st <= st;
      endcase
    end else if (st == S_RWAIT && fall) begin
      st <= S_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr_q] <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (we) begin
      cnt <= CW'(WR_CYCLES);
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      rd_q <= '0;
    end else if (cs_idle) begin
      oe_q <= 1'b0;
    end else if (st == S_RWAIT && fall) begin
      oe_q <= 1'b1;
      rd_q <= mem[addr_q];
    end
  end

  // R1
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !bus_oe);

  // R5
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(st) == S_RWAIT && $past(fall));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && $past(bus_oe) |-> $stable(bus_o));

  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(st) == S_DAT);

  // R9
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> rdy_o);

  // R3
  dead_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DEAD && !cs_idle |=> st == S_DEAD);

endmodule

// File: tb/pflash_cmd_port_tb.sv
module pflash_cmd_port_tb;
  localparam int MEM_BYTES = 4096;
  localparam int WR_CYCLES = 32;
  localparam int AW = $clog2(MEM_BYTES);

  logic clk = 0, rst_n = 0, csn_i = 1, strb_i = 0;
  logic [7:0] bus_i = 0;
  logic [7:0] bus_o;
  logic bus_oe, rdy_o;

  int checks = 0, errors = 0;
  logic [7:0] model [MEM_BYTES];
  bit         known [MEM_BYTES];

  pflash_cmd_port #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .strb_i(strb_i),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .rdy_o(rdy_o));

  always #2 clk = ~clk;

  function automatic int addr_of(input logic [7:0] ah, input logic [7:0] al);
    return int'({ah, al}) % MEM_BYTES;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo; csn_i = 0; clks(4); endtask
  task automatic cs_hi; csn_i = 1; clks(5); endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk); bus_i = b; clks(3);
    strb_i = 1; clks(5);
    strb_i = 0; clks(5);
  endtask

  task automatic wait_rdy;
    for (int k = 0; k < 1000 && !rdy_o; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] ah, al, d);
    cs_lo;
    strobe(8'hAA); strobe(8'h01); strobe(ah); strobe(al); strobe(d);
    wait_rdy; cs_hi;
    model[addr_of(ah, al)] = d;
    known[addr_of(ah, al)] = 1;
  endtask

  task automatic rd_body(input logic [7:0] ah, al, input string req);
    int a;
    a = addr_of(ah, al);
    strobe(8'hAA); strobe(8'h02); strobe(ah);
    @(negedge clk); bus_i = al; clks(3);
    strb_i = 1; clks(5);
    chk(bus_oe == 0, "R5 oe before fourth fall", bus_oe, 0);
    strb_i = 0; clks(5);
    chk(bus_oe == 1, "R5 oe after fourth fall", bus_oe, 1);
    if (known[a]) chk(bus_o == model[a], req, bus_o, model[a]);
    clks(7);
    chk(bus_oe == 1 && bus_o == model[a], "R6 data held", bus_o, model[a]);
  endtask

  task automatic rd(input logic [7:0] ah, al, input string req);
    cs_lo; rd_body(ah, al, req); cs_hi;
    chk(bus_oe == 0, "R1/R6 released at cs high", bus_oe, 0);
  endtask

  logic wd_fired = 0;
  initial begin
    #700000;
    wd_fired = 1;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    foreach (known[i]) known[i] = 0;
    clks(3); rst_n = 1; clks(3);
    chk(bus_oe == 0, "R1 reset oe", bus_oe, 0);
    chk(rdy_o == 1, "R8 reset rdy", rdy_o, 1);

    // R2/R4 directed write, R8 busy length
    begin
      int n = 0;
      cs_lo;
      strobe(8'hAA); strobe(8'h01); strobe(8'h01); strobe(8'h23);
      @(negedge clk); bus_i = 8'h5C; clks(3);
      strb_i = 1;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (k == 5) strb_i = 0;
        if (!rdy_o) n++;
        else if (n > 0) break;
      end
      chk(n == WR_CYCLES, "R8 busy length", n, WR_CYCLES);
      cs_hi;
      model[12'h123] = 8'h5C; known[12'h123] = 1;
    end
    rd(8'h01, 8'h23, "R4 read back directed");

    // R10 high address bits ignored
    wr(8'hF4, 8'h56, 8'hE1);
    rd(8'h04, 8'h56, "R10 alias read");

    // R3 bad preamble
    cs_lo; strobe(8'h55); strobe(8'hAA); strobe(8'h01); strobe(8'h04); strobe(8'h56); strobe(8'h00);
    clks(3);
    chk(rdy_o == 1, "R3 no write started", rdy_o, 1);
    cs_hi;
    rd(8'h04, 8'h56, "R3 memory unchanged");

    // R11 abort mid-command
    cs_lo; strobe(8'hAA); strobe(8'h01); cs_hi;
    rd(8'h01, 8'h23, "R11 fresh after abort");

    // R9 strobe during busy ignored
    cs_lo;
    strobe(8'hAA); strobe(8'h01); strobe(8'h00); strobe(8'h10);
    @(negedge clk); bus_i = 8'h77; clks(3); strb_i = 1; clks(5); strb_i = 0;
    model[16] = 8'h77; known[16] = 1;
    cs_hi; csn_i = 0; clks(2);
    @(negedge clk); bus_i = 8'h55; strb_i = 1; clks(3);
    chk(rdy_o == 0, "R9 still busy during stray strobe", rdy_o, 0);
    strb_i = 0; clks(3);
    wait_rdy;
    rd_body(8'h00, 8'h10, "R9 stray strobe ignored");
    cs_hi;

    // random writes, illegal opcodes, read-back
    begin
      logic [7:0] ahs [12];
      logic [7:0] als [12];
      for (int i = 0; i < 12; i++) begin
        ahs[i] = 8'($urandom); als[i] = 8'($urandom);
        wr(ahs[i], als[i], 8'($urandom));
      end
      for (int i = 0; i < 6; i++) begin
        logic [7:0] op;
        op = 8'($urandom);
        if (op == 8'h01 || op == 8'h02) op = 8'h80;
        cs_lo; strobe(8'hAA); strobe(op); strobe(ahs[i]); strobe(als[i]); strobe(8'($urandom));
        clks(2);
        chk(rdy_o == 1, "R7 no busy on illegal opcode", rdy_o, 1);
        cs_hi;
      end
      for (int i = 0; i < 12; i++) rd(ahs[i], als[i], "R7/R4 random read back");
    end

    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule